// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into an attached programmable device over a passive serial link. When it receives a start request, it pulls an active-low configuration request low for a fixed hold time. It then checks that the target has entered reset, releases the request, and polls the target's status line at fixed intervals until the target signals that it is ready. A variant input chooses between two timing sets, A and B. The variant sets the longest time the block waits for the target to become ready. It also sets the settle time between the target becoming ready and the first serial clock.

Bitstream bytes arrive on a valid/ready stream, and the block shifts each one out least-significant bit first on a serial clock/data pair. An option bit-reverses every byte first, for images stored most-significant bit first. After the byte marked last has been shifted, the block checks the status line and, if enabled, the configuration-done line. It then sends eight trailing clocks with zero data so that the target can start up. The outcome goes to the host as a one-cycle done or error pulse together with an error code that stays valid until the next start.

All microsecond delays are derived from the clock frequency parameter. The status and configuration-done inputs pass through two-flop synchronizers before the block uses them.

Top module: `pss_seq`

## Requirements
- R1: A start request with `partial_i` high is refused. One cycle later `err_o` pulses with `err_code_o` = 1, and `cfg_req_n_o` stays high the whole time.
- R2: Any other start drives `cfg_req_n_o` low from the next cycle, for exactly the hold time of 2 µs in clock cycles.
- R3: At the end of the hold, if the synchronized `tgt_status_i` is high (target not in reset), the load ends with `err_code_o` = 2.
- R4: After the hold, `cfg_req_n_o` is high and the status line is sampled at the end of each 268 µs window. The number of windows is ceil(max wait / 268 µs): 6 for variant A (1506 µs, `variant_i` = 0) and 12 for variant B (3000 µs, `variant_i` = 1).
- R5: If status is still low after the last allowed window, the load ends with `err_code_o` = 3.
- R6: Once status is seen high, the block waits the settle time before it accepts data: 2 µs for variant A and 10 µs for variant B.
- R7: `s_ready_o` is high only in the data phase while no byte is being shifted. Each accepted byte becomes 8 bits, least-significant first. Each bit takes one cycle with `ser_clk_o` low and then one cycle with it high, and `ser_dat_o` holds the bit through both cycles.
- R8: With `msb_first_i` high at start, every byte is bit-reversed before shifting, so bit 7 of the input goes out first.
- R9: After the last byte, if the synchronized status is low, the load ends with `err_code_o` = 4 and no trailing clocks.
- R10: With `done_chk_i` high at start, a low synchronized `tgt_done_i` after the data ends the load with `err_code_o` = 5. With `done_chk_i` low, `tgt_done_i` has no effect.
- R11: After the checks pass, the block sends 8 trailing serial clocks with data 0, then pulses `done_o` for one cycle and drops `busy_o`. `done_o` and `err_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (taken while idle) |
| partial_i | input | 1 | Start requests a partial load; refused |
| variant_i | input | 1 | Timing set: 0 = A, 1 = B |
| msb_first_i | input | 1 | Bytes are stored MSB first; reverse before shifting |
| done_chk_i | input | 1 | Enable the configuration-done check |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the final one |
| s_ready_o | output | 1 | Byte accepted when high together with valid |
| cfg_req_n_o | output | 1 | Active-low configuration request to target |
| ser_clk_o | output | 1 | Serial configuration clock |
| ser_dat_o | output | 1 | Serial configuration data |
| tgt_status_i | input | 1 | Target status; low = in reset or error |
| tgt_done_i | input | 1 | Target configuration-done, high when complete |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse: load completed |
| err_o | output | 1 | One-cycle pulse: load failed |
| err_code_o | output | 3 | Cause of the last failure (0 none, 1..5 per requirements) |

## Verification
The bench builds the block with a 2 MHz clock frequency parameter. That turns the hold into 4 cycles, a poll window into 536 cycles and the settle times into 4 and 20 cycles, so every window count can be run to its end. The 12-window wait of variant B, including a release in its last window, therefore fits in a short run. These values also place every per-cycle edge of the hold, the settle time and the trailing clocks where the bench's cycle-by-cycle script can predict it exactly.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_POLL,
        ST_SETTLE,
        ST_DATA,
        ST_CHECK,
        ST_TAIL
    } pss_state_e;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_REFUSED   = 3'd1,
        E_NO_RESET  = 3'd2,
        E_NOT_READY = 3'd3,
        E_CFG       = 3'd4,
        E_NO_DONE   = 3'd5
    } pss_err_e;

    typedef struct packed {
        logic var_b;
        logic msb_first;
        logic done_chk;
    } pss_opts_t;

    localparam int unsigned HOLD_US_DEF     = 2;
    localparam int unsigned POLL_US_DEF     = 268;
    localparam int unsigned MAXWAIT_A_DEF   = 1506;
    localparam int unsigned MAXWAIT_B_DEF   = 3000;
    localparam int unsigned SETTLE_A_DEF    = 2;
    localparam int unsigned SETTLE_B_DEF    = 10;

    function automatic int unsigned us_to_cyc(input longint unsigned freq_hz,
                                              input int unsigned us);
        longint unsigned c;
        c = (freq_hz * longint'(us) + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [W-1:0] stab;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            stab <= RST_VAL;
        end else begin
            meta <= d;
            stab <= meta;
        end
    end

    assign q = stab;
endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2, R4, R6: every timed window shrinks by one per cycle once loaded
    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pss_shift.sv
module pss_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       busy,
    output logic       dclk_o,
    output logic       dat_o
);
    logic [7:0] sreg;
    logic [3:0] ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ph   <= '0;
            sreg <= '0;
        end else if (load) begin
            busy <= 1'b1;
            ph   <= '0;
            sreg <= byte_i;
        end else if (busy) begin
            ph <= ph + 4'd1;
            if (ph[0])       sreg <= sreg >> 1;
            if (ph == 4'd15) busy <= 1'b0;
        end
    end

    assign dclk_o = busy & ph[0];
    assign dat_o  = busy & sreg[0];

    // R7: data never changes on the cycle the serial clock rises
    assert_data_stable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_o) |-> $stable(dat_o));
endmodule

// File: rtl/pss_seq.sv
module pss_seq
    import pss_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ  = 50_000_000,
    parameter int unsigned HOLD_US      = HOLD_US_DEF,
    parameter int unsigned POLL_US      = POLL_US_DEF,
    parameter int unsigned MAXWAIT_A_US = MAXWAIT_A_DEF,
    parameter int unsigned MAXWAIT_B_US = MAXWAIT_B_DEF,
    parameter int unsigned SETTLE_A_US  = SETTLE_A_DEF,
    parameter int unsigned SETTLE_B_US  = SETTLE_B_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic       variant_i,
    input  logic       msb_first_i,
    input  logic       done_chk_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       cfg_req_n_o,
    output logic       ser_clk_o,
    output logic       ser_dat_o,
    input  logic       tgt_status_i,
    input  logic       tgt_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [2:0] err_code_o
);
    localparam int unsigned CYC_HOLD  = us_to_cyc(CLK_FREQ_HZ, HOLD_US);
    localparam int unsigned CYC_POLL  = us_to_cyc(CLK_FREQ_HZ, POLL_US);
    localparam int unsigned CYC_SET_A = us_to_cyc(CLK_FREQ_HZ, SETTLE_A_US);
    localparam int unsigned CYC_SET_B = us_to_cyc(CLK_FREQ_HZ, SETTLE_B_US);
    localparam int unsigned NPOLL_A   = ceil_div(MAXWAIT_A_US, POLL_US);
    localparam int unsigned NPOLL_B   = ceil_div(MAXWAIT_B_US, POLL_US);
    localparam int unsigned CYC_MAX   = umax(umax(CYC_HOLD, CYC_POLL), umax(CYC_SET_A, CYC_SET_B));
    localparam int TW = $clog2(CYC_MAX + 1);
    localparam int PW = $clog2(umax(NPOLL_A, NPOLL_B) + 1);

    localparam logic [TW-1:0] HOLD_LD  = TW'(CYC_HOLD - 1);
    localparam logic [TW-1:0] POLL_LD  = TW'(CYC_POLL - 1);
    localparam logic [TW-1:0] SETA_LD  = TW'(CYC_SET_A - 1);
    localparam logic [TW-1:0] SETB_LD  = TW'(CYC_SET_B - 1);

    pss_state_e st, nxt;
    pss_opts_t  opts;
    pss_err_e   code_q, fin_code;
    logic       done_q, err_q, fin_done, fin_err;
    logic       last_seen;
    logic [PW-1:0] poll_cnt, last_poll;
    logic       poll_inc;
    logic       tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic       sh_load, sh_busy;
    logic [7:0] sh_byte;
    logic [1:0] sync_q;
    logic       stat_ok, cdone_s;

    pss_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst(rst), .d({tgt_done_i, tgt_status_i}), .q(sync_q)
    );
    assign stat_ok = sync_q[0];
    assign cdone_s = sync_q[1];

    pss_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    pss_shift u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .byte_i(sh_byte),
        .busy(sh_busy), .dclk_o(ser_clk_o), .dat_o(ser_dat_o)
    );

    assign last_poll   = opts.var_b ? PW'(NPOLL_B - 1) : PW'(NPOLL_A - 1);
    assign s_ready_o   = (st == ST_DATA) && !sh_busy && !last_seen;
    assign cfg_req_n_o = (st != ST_HOLD);
    assign busy_o      = (st != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign err_code_o  = code_q;

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_byte  = opts.msb_first ? rev8(s_data_i) : s_data_i;
        fin_done = 1'b0;
        fin_err  = 1'b0;
        fin_code = E_NONE;
        poll_inc = 1'b0;
        unique case (st)
            ST_IDLE: if (start_i) begin
                if (partial_i) begin
                    fin_err  = 1'b1;
                    fin_code = E_REFUSED;
                end else begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD: if (tmr_zero) begin
                if (stat_ok) begin
                    fin_err  = 1'b1;
                    fin_code = E_NO_RESET;
                end else begin
                    nxt      = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LD;
                end
            end
            ST_POLL: if (tmr_zero) begin
                if (stat_ok) begin
                    nxt      = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = opts.var_b ? SETB_LD : SETA_LD;
                end else if (poll_cnt == last_poll) begin
                    fin_err  = 1'b1;
                    fin_code = E_NOT_READY;
                end else begin
                    poll_inc = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LD;
                end
            end
            ST_SETTLE: if (tmr_zero) nxt = ST_DATA;
            ST_DATA: begin
                if (s_ready_o && s_valid_i) sh_load = 1'b1;
                else if (last_seen && !sh_busy) nxt = ST_CHECK;
            end
            ST_CHECK: begin
                if (!stat_ok) begin
                    fin_err  = 1'b1;
                    fin_code = E_CFG;
                end else if (opts.done_chk && !cdone_s) begin
                    fin_err  = 1'b1;
                    fin_code = E_NO_DONE;
                end else begin
                    nxt     = ST_TAIL;
                    sh_load = 1'b1;
                    sh_byte = 8'h00;
                end
            end
            ST_TAIL: if (!sh_busy) begin
                nxt      = ST_IDLE;
                fin_done = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
        if (fin_err) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            opts      <= '0;
            code_q    <= E_NONE;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            last_seen <= 1'b0;
            poll_cnt  <= '0;
        end else begin
            st     <= nxt;
            done_q <= fin_done;
            err_q  <= fin_err;
            if (st == ST_IDLE && start_i) begin
                opts.var_b     <= variant_i;
                opts.msb_first <= msb_first_i;
                opts.done_chk  <= done_chk_i;
                code_q         <= E_NONE;
                last_seen      <= 1'b0;
            end
            if (fin_err) code_q <= fin_code;
            if (st == ST_DATA && sh_load) last_seen <= s_last_i;
            if (st == ST_HOLD)  poll_cnt <= '0;
            else if (poll_inc)  poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // R1: a partial request never touches the config output and is refused
    assert_refuse_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_i && partial_i) |=> (err_o && err_code_o == 3'd1 && cfg_req_n_o));

    // R2: the config request only falls as the answer to a start
    assert_hold_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_req_n_o) |-> $past(start_i));

    // R4: the poll index stays inside the variant's window budget
    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL) |-> (poll_cnt <= last_poll));

    // R7: bytes are taken only while the serial clock rests low
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> !ser_clk_o);

    // R11: outcome flags are exclusive single-cycle pulses
    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o}));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/pss_seq_tb.sv
module pss_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ    = 2_000_000;
    localparam int T_HOLD  = 4;
    localparam int T_POLL  = 536;
    localparam int T_SET_A = 4;
    localparam int T_SET_B = 20;
    localparam int N_A     = 6;
    localparam int N_B     = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, partial_i = 0, variant_i = 0, msb_first_i = 0, done_chk_i = 0;
    logic [7:0] s_data_i = '0;
    logic s_valid_i = 0, s_last_i = 0;
    logic tgt_status_i = 1'b1, tgt_done_i = 1'b0;
    logic s_ready_o, cfg_req_n_o, ser_clk_o, ser_dat_o, busy_o, done_o, err_o;
    logic [2:0] err_code_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] byte_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pss_seq #(.CLK_FREQ_HZ(FREQ)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i),
        .variant_i(variant_i), .msb_first_i(msb_first_i), .done_chk_i(done_chk_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .cfg_req_n_o(cfg_req_n_o), .ser_clk_o(ser_clk_o),
        .ser_dat_o(ser_dat_o), .tgt_status_i(tgt_status_i), .tgt_done_i(tgt_done_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    // one clock of the reference: expected outputs for this cycle
    task automatic step(string req, bit e_cfg, bit e_clk, bit e_dat,
                        bit e_busy, bit e_done, bit e_err, bit e_rdy);
        logic [6:0] got, exp;
        @(negedge clk);
        got = {cfg_req_n_o, ser_clk_o, ser_dat_o, busy_o, done_o, err_o, s_ready_o};
        exp = {e_cfg, e_clk, e_dat, e_busy, e_done, e_err, e_rdy};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t cfg_n/clk/dat/busy/done/err/rdy got %b expected %b",
                     req, $time, got, exp);
        end
    endtask

    task automatic chk_code(string req, logic [2:0] exp);
        checks++;
        if (err_code_o !== exp) begin
            errors++;
            $display("FAIL %s err_code got %0d expected %0d", req, err_code_o, exp);
        end
    endtask

    // rel_win: -2 target never enters reset, -1 never ready, else window index of release
    task automatic run_case(bit vb, bit msb, bit dchk, bit dval, bit part, int rel_win, bit drop);
        int npoll = vb ? N_B : N_A;
        int nset  = vb ? T_SET_B : T_SET_A;
        int n     = byte_q.size();
        bit eb;
        tgt_done_i = dval;
        start_i = 1; partial_i = part; variant_i = vb; msb_first_i = msb; done_chk_i = dchk;
        if (part) begin
            step("R1", 1, 0, 0, 0, 0, 1, 0);
            chk_code("R1", 3'd1);
            start_i = 0; partial_i = 0;
            step("R1", 1, 0, 0, 0, 0, 0, 0);
            return;
        end
        step("R2", 0, 0, 0, 1, 0, 0, 0);
        start_i = 0;
        tgt_status_i = (rel_win == -2);
        repeat (T_HOLD - 1) step("R2", 0, 0, 0, 1, 0, 0, 0);
        if (rel_win == -2) begin
            step("R3", 1, 0, 0, 0, 0, 1, 0);
            chk_code("R3", 3'd2);
            return;
        end
        if (rel_win < 0) begin
            repeat (npoll * T_POLL) step("R4", 1, 0, 0, 1, 0, 0, 0);
            step("R5", 1, 0, 0, 0, 0, 1, 0);
            chk_code("R5", 3'd3);
            tgt_status_i = 1;
            return;
        end
        for (int i = 1; i <= (rel_win + 1) * T_POLL; i++) begin
            step("R4", 1, 0, 0, 1, 0, 0, 0);
            if (i == rel_win * T_POLL + 5) tgt_status_i = 1;
        end
        repeat (nset) step("R6", 1, 0, 0, 1, 0, 0, 0);
        s_valid_i = 1; s_data_i = byte_q[0]; s_last_i = (n == 1);
        for (int j = 0; j < n; j++) begin
            step("R7", 1, 0, 0, 1, 0, 0, 1);
            for (int k = 0; k < 8; k++) begin
                eb = msb ? byte_q[j][7-k] : byte_q[j][k];
                step(msb ? "R8" : "R7", 1, 0, eb, 1, 0, 0, 0);
                if (k == 0) begin
                    if (j + 1 < n) begin
                        s_data_i = byte_q[j+1]; s_last_i = (j + 2 == n);
                    end else begin
                        s_valid_i = 0; s_last_i = 0;
                    end
                    if (drop && j == 0) tgt_status_i = 0;
                end
                step(msb ? "R8" : "R7", 1, 1, eb, 1, 0, 0, 0);
            end
        end
        step("R7", 1, 0, 0, 1, 0, 0, 0);
        step("R9", 1, 0, 0, 1, 0, 0, 0);
        if (drop) begin
            step("R9", 1, 0, 0, 0, 0, 1, 0);
            chk_code("R9", 3'd4);
            tgt_status_i = 1;
            return;
        end
        if (dchk && !dval) begin
            step("R10", 1, 0, 0, 0, 0, 1, 0);
            chk_code("R10", 3'd5);
            return;
        end
        for (int k = 0; k < 8; k++) begin
            step("R11", 1, 0, 0, 1, 0, 0, 0);
            step("R11", 1, 1, 0, 1, 0, 0, 0);
        end
        step("R11", 1, 0, 0, 1, 0, 0, 0);
        step((!dchk && !dval) ? "R10" : "R11", 1, 0, 0, 0, 1, 0, 0);
        chk_code("R11", 3'd0);
    endtask

    task automatic gap();
        repeat (2) step("idle", 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 0;
        step("reset", 1, 0, 0, 0, 0, 0, 0);
        chk_code("reset", 3'd0);
        run_case(0, 0, 0, 0, 1, 0, 0);   gap();   // R1 refusal
        run_case(0, 0, 0, 0, 0, -2, 0);  gap();   // R3 no reset seen
        run_case(0, 0, 0, 0, 0, -1, 0);  gap();   // R5 variant A, 6 windows
        run_case(1, 0, 0, 0, 0, -1, 0);  gap();   // R5 variant B, 12 windows
        byte_q = '{8'hA5, 8'h3C};
        run_case(0, 0, 0, 0, 0, 1, 0);   gap();   // LSB first, done check off
        byte_q = '{8'h81, 8'h1F, 8'hC2};
        run_case(1, 1, 1, 1, 0, 11, 0);  gap();   // MSB first, last window release
        byte_q = '{8'h55};
        run_case(0, 0, 0, 1, 0, 0, 1);   gap();   // R9 status error after data
        byte_q = '{8'h0F};
        run_case(0, 0, 1, 0, 0, 0, 0);   gap();   // R10 done missing
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100_000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule